// File: doc/BRIEF.md
# USB Device Interrupt Status Unit

This block gathers interrupt causes from the sixteen endpoints of a full-speed USB device controller and turns them into a single interrupt request for the host processor. Endpoints 1 to 15 each deliver a one-cycle event pulse. Endpoint 0 instead provides three level flags from its control/status logic: OUT data waiting, IN buffer loaded, and a STALL handshake that has been sent. The unit derives one endpoint 0 cause from these three flags.

Each endpoint has one mask bit and one status bit. A set mask bit stops the status bit from being set in the first place. A status bit that is already set is not hidden by its mask bit. Software reads the status through a small register bus and clears bits by writing ones. The request line stays active while any status bit is set. It is registered, so it follows the status bits one cycle later.

The register bus is a single-cycle interface with select, write, a 2-bit address and 32-bit data. Read data is combinational and valid in the same cycle while a read is selected.

Top module: `usb_irq_status`

## Requirements
- R1: After reset, both status registers read 0x00000000, both mask registers read 0x000000FF, and `irq_o` is low.
- R2: A pulse on `ep_evt[n]` (n = 1..15) whose mask bit is 0 sets status bit n. The bit is visible on the next read after the clock edge that samples the pulse.
- R3: A pulse on an endpoint whose mask bit is 1 leaves that status bit at 0 (mask encoding: 1 = disabled, 0 = enabled).
- R4: A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When an endpoint's set condition and a write-1-to-clear for the same bit land in the same cycle, the bit ends up set.
- R6: Status bit 0 is set when its mask is 0 and the condition (OUT-ready = 1 OR IN-ready = 0 OR STALL-sent = 1) goes from false to true. A condition held true does not set the bit again after software clears it.
- R7: `irq_o` rises one cycle after the first status bit becomes set. It falls one cycle after the last status bit clears.
- R8: Writing a mask bit to 1 leaves an already set status bit at 1 until it is cleared by software.
- R9: Bits 31:8 of every register read as 0, and writes to those bits have no effect.
- R10: Address map: 0 = status for endpoints 7..0, 1 = status for endpoints 15..8, 2 = mask for endpoints 7..0, 3 = mask for endpoints 15..8. In each register, bit k belongs to endpoint 8*(address mod 2)+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected, 0 otherwise |
| ep0_out_rdy | input | 1 | Endpoint 0 OUT data waiting flag |
| ep0_in_rdy | input | 1 | Endpoint 0 IN buffer loaded flag |
| ep0_stall_sent | input | 1 | Endpoint 0 STALL handshake sent flag |
| ep_evt | input | 15 | Event pulses, bit n for endpoint n (n = 1..15) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default of sixteen endpoints. That gives two status/mask register pairs, so every address decode path is exercised, including the upper-bank registers and their reserved bits. The table-driven part places single events at both ends of each bank against mask patterns that enable or block them. The directed tests cover the three endpoint 0 conditions, a held condition after a clear, and a set and a clear landing together. They also cover the one-cycle lag of the request line.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  // endpoints carried by one status or mask register
  localparam int unsigned EP_PER_REG = 8;
  localparam int unsigned BUS_DW     = 32;

  typedef logic [EP_PER_REG-1:0] ep_slice_t;

  // endpoint 0 raises a cause on any of these flag states
  function automatic logic ep0_cause(input logic out_rdy, input logic in_rdy, input logic stall);
    return out_rdy | ~in_rdy | stall;
  endfunction
endpackage

// File: rtl/usb_irq_ep0_detect.sv
module usb_irq_ep0_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic out_rdy_i,
  input  logic in_rdy_i,
  input  logic stall_i,
  output logic rise_o
);
  import usb_irq_pkg::*;

  logic cause_now;
  logic cause_q;
  logic cause_d;

  always_comb begin
    cause_now = ep0_cause(out_rdy_i, in_rdy_i, stall_i);
    cause_d   = cause_now;
    rise_o    = cause_now & ~cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= 1'b0;
    else        cause_q <= cause_d;
  end

  // R6: a held condition produces only one edge
  p_single_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/usb_irq_stat_bank.sv
module usb_irq_stat_bank #(
  parameter int unsigned NUM_EP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] set_i,
  input  logic [NUM_EP-1:0] mask_i,
  input  logic [NUM_EP-1:0] clr_i,
  output logic [NUM_EP-1:0] stat_o
);
  logic [NUM_EP-1:0] stat_q;
  logic [NUM_EP-1:0] stat_d;
  logic [NUM_EP-1:0] stat_en;
  logic [NUM_EP-1:0] set_ok;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_bit
    always_comb begin
      set_ok[i]  = set_i[i] & ~mask_i[i];
      stat_en[i] = set_ok[i] | clr_i[i];
      stat_d[i]  = set_ok[i];   // set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q[i] <= 1'b0;
      else if (stat_en[i]) stat_q[i] <= stat_d[i];
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && !mask_i[i]) |=> stat_q[i]);
    p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[i] && mask_i[i]) |=> !stat_q[i]);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !stat_q[i]);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/usb_irq_regbus.sv
module usb_irq_regbus #(
  parameter int unsigned NUM_REGS = 2,
  parameter int unsigned ADDR_W   = 2,
  localparam int unsigned SLICE   = usb_irq_pkg::EP_PER_REG,
  localparam int unsigned DW      = usb_irq_pkg::BUS_DW,
  localparam int unsigned NBITS   = NUM_REGS * SLICE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NBITS-1:0]  stat_i,
  output logic [NBITS-1:0]  mask_o,
  output logic [NBITS-1:0]  clr_o,
  output logic [DW-1:0]     rdata_o
);
  logic [NBITS-1:0]    mask_q;
  logic [NBITS-1:0]    mask_d;
  logic [NUM_REGS-1:0] mask_en;
  logic                wr_strobe;
  logic                rd_strobe;
  logic                unused_wdata_hi;

  assign wr_strobe       = sel_i & wr_i;
  assign rd_strobe       = sel_i & ~wr_i;
  assign unused_wdata_hi = ^wdata_i[DW-1:SLICE];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_comb begin
      mask_en[k] = wr_strobe && (addr_i == ADDR_W'(NUM_REGS + k));
      mask_d[k*SLICE +: SLICE] = wdata_i[SLICE-1:0];
      clr_o[k*SLICE +: SLICE]  = (wr_strobe && (addr_i == ADDR_W'(k)))
                                 ? wdata_i[SLICE-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q[k*SLICE +: SLICE] <= '1;
      else if (mask_en[k]) mask_q[k*SLICE +: SLICE] <= mask_d[k*SLICE +: SLICE];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_strobe) begin
      for (int k = 0; k < int'(NUM_REGS); k++) begin
        if (addr_i == ADDR_W'(k))
          rdata_o[SLICE-1:0] = stat_i[k*SLICE +: SLICE];
        if (addr_i == ADDR_W'(NUM_REGS + k))
          rdata_o[SLICE-1:0] = mask_q[k*SLICE +: SLICE];
      end
    end
  end

  assign mask_o = mask_q;

  // R9: upper bits of a read never carry data
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (rdata_o[DW-1:SLICE] == '0));
  // R10: a mask write lands in the mask on the next cycle
  p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && addr_i == ADDR_W'(NUM_REGS)) |=> (mask_q[SLICE-1:0] == $past(wdata_i[SLICE-1:0])));
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status #(
  parameter int unsigned NUM_EP    = 16,
  localparam int unsigned NUM_REGS = NUM_EP / usb_irq_pkg::EP_PER_REG,
  localparam int unsigned ADDR_W   = $clog2(2 * NUM_REGS),
  localparam int unsigned DW       = usb_irq_pkg::BUS_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ep0_out_rdy,
  input  logic              ep0_in_rdy,
  input  logic              ep0_stall_sent,
  input  logic [NUM_EP-1:1] ep_evt,
  output logic              irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              ep0_rise;
  logic [NUM_EP-1:0] set_vec;
  logic [NUM_EP-1:0] mask_vec;
  logic [NUM_EP-1:0] clr_vec;
  logic [NUM_EP-1:0] stat_vec;
  logic              any_stat;
  logic              irq_q;
  logic              irq_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  usb_irq_ep0_detect u_ep0 (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .out_rdy_i (ep0_out_rdy),
    .in_rdy_i  (ep0_in_rdy),
    .stall_i   (ep0_stall_sent),
    .rise_o    (ep0_rise)
  );

  assign set_vec = {ep_evt, ep0_rise};

  usb_irq_regbus #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bus (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel_i   (bus_sel),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .stat_i  (stat_vec),
    .mask_o  (mask_vec),
    .clr_o   (clr_vec),
    .rdata_o (bus_rdata)
  );

  usb_irq_stat_bank #(.NUM_EP(NUM_EP)) u_stat (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (set_vec),
    .mask_i (mask_vec),
    .clr_i  (clr_vec),
    .stat_o (stat_vec)
  );

  always_comb begin
    any_stat = |stat_vec;
    irq_d    = any_stat;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    any_stat |=> irq_o);
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !any_stat |=> !irq_o);
endmodule

// File: tb/usb_irq_status_tb_top.sv
`timescale 1ns/1ps
module usb_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ep0_out_rdy;
  logic        ep0_in_rdy;
  logic        ep0_stall_sent;
  logic [15:1] ep_evt;
  logic        irq_o;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  usb_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ep0_out_rdy(ep0_out_rdy), .ep0_in_rdy(ep0_in_rdy),
    .ep0_stall_sent(ep0_stall_sent), .ep_evt(ep_evt), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [3:0] ep;
    logic [7:0] mlo;
    logic [7:0] mhi;
    logic [7:0] elo;
    logic [7:0] ehi;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{ep:4'd1,  mlo:8'h00, mhi:8'hFF, elo:8'h02, ehi:8'h00},
    '{ep:4'd7,  mlo:8'h7F, mhi:8'hFF, elo:8'h80, ehi:8'h00},
    '{ep:4'd7,  mlo:8'h80, mhi:8'h00, elo:8'h00, ehi:8'h00},
    '{ep:4'd8,  mlo:8'hFF, mhi:8'hFE, elo:8'h00, ehi:8'h01},
    '{ep:4'd15, mlo:8'hFF, mhi:8'h7F, elo:8'h00, ehi:8'h80},
    '{ep:4'd9,  mlo:8'h00, mhi:8'h02, elo:8'h00, ehi:8'h00},
    '{ep:4'd12, mlo:8'hFF, mhi:8'h00, elo:8'h00, ehi:8'h10},
    '{ep:4'd4,  mlo:8'hEF, mhi:8'h00, elo:8'h10, ehi:8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input int ep);
    @(negedge clk);
    ep_evt[ep] = 1'b1;
    @(negedge clk);
    ep_evt = '0;
  endtask

  task automatic clear_all();
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_write(2'd1, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ep0_out_rdy = 1'b0; ep0_in_rdy = 1'b1; ep0_stall_sent = 1'b0; ep_evt = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd); chk("R1 stat lo", rd, 32'h0);
    bus_read(2'd1, rd); chk("R1 stat hi", rd, 32'h0);
    bus_read(2'd2, rd); chk("R1 mask lo", rd, 32'hFF);
    bus_read(2'd3, rd); chk("R1 mask hi", rd, 32'hFF);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // table: R2 R3 R10
    for (int v = 0; v < NVEC; v++) begin
      bus_write(2'd2, {24'h0, VEC[v].mlo});
      bus_write(2'd3, {24'h0, VEC[v].mhi});
      pulse(int'(VEC[v].ep));
      bus_read(2'd0, rd); chk("R2/R3/R10 lo", rd, {24'h0, VEC[v].elo});
      bus_read(2'd1, rd); chk("R2/R3/R10 hi", rd, {24'h0, VEC[v].ehi});
      clear_all();
    end

    // R7 request timing
    bus_write(2'd2, 32'h0);
    bus_write(2'd3, 32'h0);
    pulse(5);
    chk("R7 irq lag on set", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R7 irq asserted", {31'b0, irq_o}, 32'h1);
    pulse(13);
    // R4 partial clear: clear bit 5 only, write 0 elsewhere
    bus_write(2'd0, 32'h0000_0020);
    bus_read(2'd0, rd); chk("R4 cleared bit", rd, 32'h0);
    bus_read(2'd1, rd); chk("R4 write-0 keeps", rd, 32'h20);
    chk("R7 irq held while hi set", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h20;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R7 irq lag on clear", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R7 irq deasserted", {31'b0, irq_o}, 32'h0);

    // R5 set wins over same-cycle clear
    pulse(2);
    @(negedge clk);
    ep_evt[3] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h0000_000C;
    @(negedge clk);
    ep_evt = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(2'd0, rd); chk("R5 set wins", rd, 32'h08);
    clear_all();

    // R8 masking a set bit keeps it
    pulse(10);
    bus_write(2'd3, 32'hFF);
    bus_read(2'd1, rd); chk("R8 kept after mask", rd, 32'h04);
    clear_all();
    bus_read(2'd1, rd); chk("R8 cleared by software", rd, 32'h0);

    // R9 reserved bits
    bus_write(2'd2, 32'hABCD_EF00);
    bus_read(2'd2, rd); chk("R9 mask upper ignored", rd, 32'h0);
    pulse(6);
    bus_write(2'd0, 32'hFFFF_FF00);
    bus_read(2'd0, rd); chk("R9 upper clear ignored", rd, 32'h40);
    clear_all();

    // R6 endpoint 0 conditions
    @(negedge clk); ep0_out_rdy = 1'b1;
    @(negedge clk);
    bus_read(2'd0, rd); chk("R6 out ready", rd, 32'h01);
    clear_all();
    bus_read(2'd0, rd); chk("R6 held level no reset", rd, 32'h0);
    @(negedge clk); ep0_out_rdy = 1'b0;
    @(negedge clk); ep0_in_rdy = 1'b0;
    @(negedge clk);
    bus_read(2'd0, rd); chk("R6 in not ready", rd, 32'h01);
    @(negedge clk); ep0_in_rdy = 1'b1;
    clear_all();
    @(negedge clk); ep0_stall_sent = 1'b1;
    @(negedge clk); ep0_stall_sent = 1'b0;
    bus_read(2'd0, rd); chk("R6 stall sent", rd, 32'h01);
    clear_all();
    bus_write(2'd2, 32'h01);
    @(negedge clk); ep0_out_rdy = 1'b1;
    @(negedge clk); ep0_out_rdy = 1'b0;
    bus_read(2'd0, rd); chk("R3 ep0 masked", rd, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule